// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block sits between a processor load/store port that addresses single bytes and a backing memory that returns 32-bit words. It keeps four lines. Each line holds a valid flag, a tag and an 8-byte block. Every processor address is divided into three fields. Bits [2:0] are the byte offset, bits [4:3] choose the line, and the remaining high bits form the tag, which is compared against the stored tag of the chosen line.

**Reads**
- A read that hits returns its byte combinationally, in the same cycle as the request.
- A read that misses issues one block-aligned read request to memory. The block then arrives as a burst of word beats, and the indexed line is overwritten whatever it held.
- Once the burst is complete, the same read completes as a hit.

**Writes**
- Writes are write-through with no-write-allocate. Every write goes to memory, and the processor is stalled until memory acknowledges it.
- A write hit also updates the cached byte.
- A write miss leaves the cache untouched.

**Processor protocol**
The processor holds its request, direction, address and write byte steady until `cpu_ready_o` is high.

Top module: `dmc_cache`

## Requirements
- R1: After reset every line is invalid. With no request pending, `mem_req_o` and `cpu_ready_o` are low, and the first read to each of the four lines misses.
- R2: The byte offset is address bits [2:0] and the line index is bits [4:3]. The tag is bits [15:5]. A hit needs a set valid flag and a stored tag equal to the address tag, so two addresses that differ only in their tag do not share a hit.
- R3: A read hit raises `cpu_ready_o` in the request cycle with the addressed byte on `cpu_rdata_o`, and raises no memory request.
- R4: A read miss keeps `cpu_ready_o` low. It raises `mem_req_o` with `mem_we_o` low and `mem_addr_o` equal to the address with bits [2:0] cleared. No further request is made while the beats are awaited.
- R5: After the acknowledge the block arrives as two beats flagged by `mem_rvalid_i`. Beat k carries block bytes 4k to 4k+3, with byte 4k+j in bits [8j+7:8j]. The cycle after the last beat, the read completes as a hit with the filled byte.
- R6: A read miss replaces the indexed line unconditionally, so the block that line held before misses on its next read.
- R7: A write raises `mem_req_o` with `mem_we_o` high, the full byte address and the write byte. `cpu_ready_o` rises only in the cycle `mem_ack_i` is high.
- R8: A write hit also updates the cached byte, so a later read of that address hits and returns the new byte.
- R9: A write miss leaves the tags, valid flags and data unchanged. The line at that index still hits for its old block, and the written address still misses.
- R10: An unacknowledged memory request stays asserted with the same address and direction until `mem_ack_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_req_i | input | 1 | Processor access request |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 16 | Byte address |
| cpu_wdata_i | input | 8 | Write byte |
| cpu_rdata_o | output | 8 | Read byte, valid when ready on a read |
| cpu_ready_o | output | 1 | Access completes this cycle |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory request is a byte write |
| mem_addr_o | output | 16 | Block address for reads, byte address for writes |
| mem_wdata_o | output | 8 | Memory write byte |
| mem_ack_i | input | 1 | Memory accepts the request (completes a write) |
| mem_rvalid_i | input | 1 | Read beat valid |
| mem_rdata_i | input | 32 | Read beat data |

## Verification
Several rules are checked by assertions on every cycle:
- Block-aligned read addresses and no memory request during a hit (R3, R4).
- Silence of the request line during a fill.
- Write completion tied to the acknowledge (R7).
- Request persistence until acknowledge (R10).
- The fill write and the byte-update write never coinciding.
- Valid flags and tags changing only on a fill completion, and a fill completion being followed by a hit.

Other behaviour depends on memory contents and access history, so only the bench's scenarios can show it:
- The bytes actually returned, including byte-lane ordering within beats.
- Eviction on a conflicting miss.
- A write hit being visible to a later read.
- A write miss allocating nothing.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } ctrl_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int IDX_W = 2,
  parameter int TAG_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             wr_en_i,
  output logic             hit_o
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0]            valid_q;
  logic [SETS-1:0][TAG_W-1:0] tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      tag_q   <= '0;
    end else if (wr_en_i) begin
      valid_q[idx_i] <= 1'b1;
      tag_q[idx_i]   <= tag_i;
    end
  end

  assign hit_o = valid_q[idx_i] && (tag_q[idx_i] == tag_i);

  // Only a completed fill may alter line state (write misses must not)
  p_state_only_on_fill_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(valid_q) && $stable(tag_q)));
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int IDX_W  = 2,
  parameter int OFF_W  = 3,
  parameter int WORD_W = 32,
  parameter int BEAT_W = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              fill_we_i,
  input  logic [BEAT_W-1:0] fill_beat_i,
  input  logic [WORD_W-1:0] fill_word_i,
  input  logic              byte_we_i,
  input  logic [7:0]        byte_i,
  output logic [7:0]        byte_o
);
  localparam int SETS       = 1 << IDX_W;
  localparam int BLK_BYTES  = 1 << OFF_W;
  localparam int WORD_BYTES = WORD_W / 8;

  logic [SETS*BLK_BYTES-1:0][7:0] flat;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    for (genvar b = 0; b < BLK_BYTES; b++) begin : g_byte
      localparam int BEAT = b / WORD_BYTES;
      localparam int LANE = b % WORD_BYTES;
      logic [7:0] byte_q;
      logic       sel_line;
      assign sel_line = (idx_i == IDX_W'(s));
      always_ff @(posedge clk_i) begin
        if (fill_we_i && sel_line && fill_beat_i == BEAT_W'(BEAT))
          byte_q <= fill_word_i[LANE*8 +: 8];
        else if (byte_we_i && sel_line && off_i == OFF_W'(b))
          byte_q <= byte_i;
      end
      assign flat[s*BLK_BYTES + b] = byte_q;
    end
  end

  assign byte_o = flat[{idx_i, off_i}];

  p_one_writer_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fill_we_i && byte_we_i));
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int BEATS  = 2,
  parameter int BEAT_W = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              hit_i,
  input  logic              mem_ack_i,
  input  logic              mem_rvalid_i,
  output logic              ready_o,
  output logic              mem_req_o,
  output logic              fill_we_o,
  output logic [BEAT_W-1:0] fill_beat_o,
  output logic              fill_done_o,
  output logic              byte_we_o
);
  ctrl_state_e       state_q, state_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              last_beat;

  assign last_beat = (beat_q == BEAT_W'(BEATS - 1));

  always_comb begin
    state_d     = state_q;
    beat_d      = beat_q;
    ready_o     = 1'b0;
    mem_req_o   = 1'b0;
    fill_we_o   = 1'b0;
    fill_done_o = 1'b0;
    byte_we_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i && we_i) begin
          mem_req_o = 1'b1;
          ready_o   = mem_ack_i;
          byte_we_o = mem_ack_i && hit_i;
        end else if (req_i) begin
          if (hit_i) begin
            ready_o = 1'b1;
          end else begin
            mem_req_o = 1'b1;
            if (mem_ack_i) begin
              state_d = ST_FILL;
              beat_d  = '0;
            end
          end
        end
      end
      ST_FILL: begin
        if (mem_rvalid_i) begin
          fill_we_o = 1'b1;
          if (last_beat) begin
            fill_done_o = 1'b1;
            beat_d      = '0;
            state_d     = ST_IDLE;
          end else begin
            beat_d = beat_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
    end
  end

  assign fill_beat_o = beat_q;

  p_quiet_in_fill_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FILL) |-> !mem_req_o);
  p_wr_done_on_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && we_i) |-> mem_ack_i);
  p_req_held_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> mem_req_o);
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 3,
  parameter int IDX_W  = 2,
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [7:0]        cpu_wdata_i,
  output logic [7:0]        cpu_rdata_o,
  output logic              cpu_ready_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i
);
  localparam int TAG_W     = ADDR_W - OFF_W - IDX_W;
  localparam int BLK_BYTES = 1 << OFF_W;
  localparam int BEATS     = (BLK_BYTES * 8) / WORD_W;
  localparam int BEAT_W    = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [OFF_W-1:0]  addr_off;
  logic [IDX_W-1:0]  addr_idx;
  logic [TAG_W-1:0]  addr_tag;
  logic              hit;
  logic              fill_we, fill_done, byte_we;
  logic [BEAT_W-1:0] fill_beat;

  assign addr_off = cpu_addr_i[OFF_W-1:0];
  assign addr_idx = cpu_addr_i[OFF_W +: IDX_W];
  assign addr_tag = cpu_addr_i[ADDR_W-1 -: TAG_W];

  dmc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .idx_i   (addr_idx),
    .tag_i   (addr_tag),
    .wr_en_i (fill_done),
    .hit_o   (hit)
  );

  dmc_data_store #(.IDX_W(IDX_W), .OFF_W(OFF_W), .WORD_W(WORD_W), .BEAT_W(BEAT_W)) u_data (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .idx_i       (addr_idx),
    .off_i       (addr_off),
    .fill_we_i   (fill_we),
    .fill_beat_i (fill_beat),
    .fill_word_i (mem_rdata_i),
    .byte_we_i   (byte_we),
    .byte_i      (cpu_wdata_i),
    .byte_o      (cpu_rdata_o)
  );

  dmc_ctrl #(.BEATS(BEATS), .BEAT_W(BEAT_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (cpu_req_i),
    .we_i         (cpu_we_i),
    .hit_i        (hit),
    .mem_ack_i    (mem_ack_i),
    .mem_rvalid_i (mem_rvalid_i),
    .ready_o      (cpu_ready_o),
    .mem_req_o    (mem_req_o),
    .fill_we_o    (fill_we),
    .fill_beat_o  (fill_beat),
    .fill_done_o  (fill_done),
    .byte_we_o    (byte_we)
  );

  // Reads fetch the whole block; writes carry the exact byte address
  assign mem_we_o    = mem_req_o && cpu_we_i;
  assign mem_addr_o  = cpu_we_i ? cpu_addr_i : {cpu_addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_wdata_o = cpu_wdata_i;

  p_hit_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && !cpu_we_i && cpu_ready_o) |-> !mem_req_o);
  p_read_aligned_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> (mem_addr_o[OFF_W-1:0] == '0));
  p_fill_then_hit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_done |=> (hit && cpu_ready_o));
endmodule

// File: tb/tb_dmc_cache.sv
module tb_dmc_cache;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata_o;
  logic        cpu_ready_o, mem_req_o, mem_we_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic        mem_ack = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int errors = 0;
  int checks = 0;

  // Reference model state
  bit         ref_valid [4];
  int         ref_tag   [4];
  logic [7:0] ref_line  [4][8];
  logic [7:0] wmem [logic [15:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  dmc_cache dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_rdata_o(cpu_rdata_o), .cpu_ready_o(cpu_ready_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_ack_i(mem_ack), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [7:0] mb(input logic [15:0] a);
    if (wmem.exists(a)) return wmem[a];
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [31:0] beat_word(input logic [15:0] base, input int k);
    logic [31:0] w;
    for (int j = 0; j < 4; j++) w[8*j +: 8] = mb(base + 16'(4*k + j));
    return w;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_read(input logic [15:0] a, input int ack_dly, input int gap, input string rq);
    int s = int'(a[4:3]);
    int t = int'(a[15:5]);
    int o = int'(a[2:0]);
    logic [15:0] base = {a[15:3], 3'b000};
    step();
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
    @(negedge clk);
    if (ref_valid[s] && ref_tag[s] == t) begin
      chk(cpu_ready_o === 1'b1, {rq, " hit ready"}, 32'(cpu_ready_o), 1);
      chk(cpu_rdata_o === ref_line[s][o], {rq, " hit data"}, 32'(cpu_rdata_o), 32'(ref_line[s][o]));
      chk(mem_req_o === 1'b0, {rq, " hit no mem R3"}, 32'(mem_req_o), 0);
    end else begin
      chk(cpu_ready_o === 1'b0, {rq, " miss stall R4"}, 32'(cpu_ready_o), 0);
      chk(mem_req_o === 1'b1 && mem_we_o === 1'b0, {rq, " miss req R4"}, 32'({mem_req_o, mem_we_o}), 32'b10);
      chk(mem_addr_o === base, {rq, " miss addr R4"}, 32'(mem_addr_o), 32'(base));
      repeat (ack_dly) begin
        step();
        @(negedge clk);
        chk(mem_req_o === 1'b1 && mem_addr_o === base && cpu_ready_o === 1'b0, "R10 held",
            32'({mem_req_o, cpu_ready_o}), 32'b10);
      end
      mem_ack = 1'b1;
      step();
      mem_ack = 1'b0;
      for (int k = 0; k < 2; k++) begin
        repeat (gap) begin
          @(negedge clk);
          chk(mem_req_o === 1'b0 && cpu_ready_o === 1'b0, "R4 fill quiet",
              32'({mem_req_o, cpu_ready_o}), 0);
          step();
        end
        mem_rvalid = 1'b1; mem_rdata = beat_word(base, k);
        step();
        mem_rvalid = 1'b0;
      end
      ref_valid[s] = 1'b1;
      ref_tag[s]   = t;
      for (int b = 0; b < 8; b++) ref_line[s][b] = mb(base + 16'(b));
      @(negedge clk);
      chk(cpu_ready_o === 1'b1, "R5 ready after fill", 32'(cpu_ready_o), 1);
      chk(cpu_rdata_o === ref_line[s][o], "R5 fill data", 32'(cpu_rdata_o), 32'(ref_line[s][o]));
    end
    step();
    cpu_req = 1'b0;
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d, input int ack_dly, input string rq);
    int s = int'(a[4:3]);
    int t = int'(a[15:5]);
    step();
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    repeat (ack_dly) begin
      @(negedge clk);
      chk(cpu_ready_o === 1'b0, {rq, " R7 stall"}, 32'(cpu_ready_o), 0);
      step();
    end
    @(negedge clk);
    chk(mem_req_o === 1'b1 && mem_we_o === 1'b1, {rq, " R7 req"}, 32'({mem_req_o, mem_we_o}), 32'b11);
    chk(mem_addr_o === a && mem_wdata_o === d, {rq, " R7 addr/data"}, {mem_addr_o, 8'h0, mem_wdata_o}, {a, 8'h0, d});
    chk(cpu_ready_o === 1'b0, {rq, " R7 no early ready"}, 32'(cpu_ready_o), 0);
    mem_ack = 1'b1;
    #1;
    chk(cpu_ready_o === 1'b1, {rq, " R7 ready on ack"}, 32'(cpu_ready_o), 1);
    step();
    mem_ack = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0;
    wmem[a] = d;
    if (ref_valid[s] && ref_tag[s] == t) ref_line[s][int'(a[2:0])] = d;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    chk(mem_req_o === 1'b0 && cpu_ready_o === 1'b0, "R1 idle after reset",
        32'({mem_req_o, cpu_ready_o}), 0);
    // R1: cold misses on all four lines, varied handshake timing
    do_read(16'h1203, 0, 0, "R1 set0");
    do_read(16'h1208, 2, 1, "R1 set1");
    do_read(16'h1216, 1, 3, "R1 set2");
    do_read(16'h121F, 0, 2, "R1 set3");
    // R3/R2: hits at several offsets
    do_read(16'h1200, 0, 0, "R3 off0");
    do_read(16'h1207, 0, 0, "R3 off7");
    do_read(16'h120C, 0, 0, "R3 set1");
    do_read(16'h1211, 0, 0, "R2 set2");
    // R6: conflicting tag evicts line 0
    do_read(16'h3405, 1, 0, "R6 conflict");
    do_read(16'h1203, 0, 1, "R6 old block refetch");
    do_read(16'h3405, 0, 0, "R6 evicted again");
    // R8: write hit updates cache and memory
    do_write(16'h3401, 8'hAA, 2, "R8 write hit");
    do_read(16'h3401, 0, 0, "R8 read new byte");
    // R9: write miss into line 2 allocates nothing
    do_write(16'h5611, 8'h77, 0, "R9 write miss");
    do_read(16'h1211, 0, 0, "R9 old line hit");
    do_read(16'h5611, 0, 0, "R9 write miss no alloc");
    do_read(16'h5611, 0, 0, "R9 hit after fill");
    // R2: high tag bits distinguish blocks at same index
    do_read(16'hFFFF, 3, 1, "R2 high tag");
    do_read(16'hFFF8, 0, 0, "R2 same block");
    do_read(16'h7FF8, 0, 0, "R2 tag msb differs");
    do_write(16'h7FFA, 8'h3C, 3, "R10 slow ack");
    do_read(16'h7FFA, 0, 0, "R8 lane2");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule